// File: doc/BRIEF.md
# Queued Conversion Command Sequencer

This block walks a shared table of 16-bit command words and turns each word into one request to an analog-to-digital converter. Two queues share the table and the converter. Queue 1 always starts at entry 0. Queue 2 starts at a programmable entry. Each queue starts on its own trigger pulse and converts its words one after another, in ascending index order. A queue ends when it reaches a word whose channel field is 63.

A pause flag in a word splits a queue into sub-queues. After that word's conversion, the queue waits for another trigger before it continues. Queue 1 outranks queue 2. A queue 1 trigger that arrives while queue 2 has a conversion in flight cancels that conversion. The block then reports the cancelled index so that software can restart queue 2 from it.

Per-queue mode inputs, a global stop input and a freeze input let software cancel or hold the work. Every result leaves the block tagged with the index of the word that produced it and with the queue that owns it. The converter is driven with a start/abort pulse pair and answers with a one-cycle done pulse.

Top module: `cmdq_sequencer`

## Requirements
- R1: A command word is read as [15:10] reserved, [9] pause, [8] bypass, [7:6] sample time, [5:0] channel. On `cnv_start`, the bypass, sample-time and channel fields of the word are presented unchanged on `cnv_byp`, `cnv_ist` and `cnv_chan`.
- R2: A trigger on an idle, enabled queue starts that queue at its base index: 0 for queue 1, `q2_base` for queue 2. Each word then gets exactly one conversion, in ascending index order, and only one conversion is in flight at a time.
- R3: Each converter done pulse produces one cycle of `res_valid`. In that cycle `res_idx` is the index of the word, `res_qsel` is the owning queue (0 = queue 1, 1 = queue 2) and `res_data` equals `cnv_data`.
- R4: A word with channel 63 ends its queue. No conversion is issued for it, the queue's done output pulses for one cycle and the queue goes idle. The next trigger restarts the queue from its base index.
- R5: After converting a word whose pause bit is set, the queue holds with its paused output high. The next trigger resumes it at the following index.
- R6: A trigger that arrives while its queue is already running is ignored.
- R7: When both queues have work, queue 1 words are issued before any queue 2 word.
- R8: If a queue 1 trigger arrives while a queue 2 conversion is in flight, and no done pulse arrives in that cycle:
  - `cnv_abort` pulses;
  - one cycle later `q2_abrt` pulses, with `q2_abrt_idx` holding the cancelled index;
  - queue 2 goes idle;
  - queue 1 runs.
- R9: Mode 0 disables a queue. Entering it cancels that queue's conversion in flight, and triggers are ignored while the mode stays 0.
- R10: Changing a queue's mode to a different nonzero value cancels its conversion in flight and makes the queue idle. The next trigger restarts it from its base index.
- R11: While `stop` is high, any conversion in flight is cancelled, both queues are idle, triggers are ignored and no word is issued.
- R12: When `frz_en` and `frz_in` are both high, a conversion in flight still completes and delivers its result, but no new word is issued. When freeze is released, the queue continues at the next index. `frz_in` has no effect while `frz_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q1_mode | input | 2 | Queue 1 mode (0 = disabled, 1..3 = enabled) |
| q2_mode | input | 2 | Queue 2 mode (0 = disabled, 1..3 = enabled) |
| q2_base | input | IDX_W | First table index of queue 2 |
| q1_trig | input | 1 | Queue 1 trigger pulse |
| q2_trig | input | 1 | Queue 2 trigger pulse |
| stop | input | 1 | Global stop level |
| frz_en | input | 1 | Freeze enable |
| frz_in | input | 1 | Freeze request |
| tbl_addr | output | IDX_W | Command table read index |
| tbl_data | input | 16 | Command word at `tbl_addr` (combinational read) |
| cnv_start | output | 1 | Start pulse to the converter |
| cnv_abort | output | 1 | Cancel the conversion in flight |
| cnv_chan | output | 6 | Channel for the conversion being started |
| cnv_byp | output | 1 | Amplifier bypass for the conversion being started |
| cnv_ist | output | 2 | Sample time for the conversion being started |
| cnv_done | input | 1 | Converter done pulse |
| cnv_data | input | DATA_W | Converter result |
| res_valid | output | 1 | Result strobe |
| res_qsel | output | 1 | Owning queue of the result |
| res_idx | output | IDX_W | Table index that produced the result |
| res_data | output | DATA_W | Result value |
| q1_done | output | 1 | Queue 1 reached its end word |
| q2_done | output | 1 | Queue 2 reached its end word |
| q1_paused | output | 1 | Queue 1 is waiting at a pause point |
| q2_paused | output | 1 | Queue 2 is waiting at a pause point |
| q2_abrt | output | 1 | Queue 2 was cancelled by queue 1 |
| q2_abrt_idx | output | IDX_W | Index of the cancelled queue 2 word |

## Verification
The assertions check four rules on every cycle:
- a pre-empting queue 1 trigger cancels queue 2 and reports the right index;
- a disabled queue's conversion is cancelled at once;
- stop and freeze keep the converter from starting;
- a paused or finished queue settles in the correct state.

Only the bench scenarios can show that whole sequences come out in the right order: ascending indices across several queue lengths, queue 1 results ahead of queue 2, and resumption at the correct entry after a pause, a freeze, a mode change or a stop. The same holds for the field forwarding and the result tagging, which the bench compares against its own copy of the table.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int WORD_W = 16;
    localparam int CHAN_W = 6;
    localparam int IST_W  = 2;
    localparam int MODE_W = 2;
    localparam logic [CHAN_W-1:0] END_CHAN = 6'd63;
    localparam logic [MODE_W-1:0] MODE_OFF = 2'd0;

    // Command word layout, most significant field first.
    typedef struct packed {
        logic [5:0]        rsvd;
        logic              pause;
        logic              byp;
        logic [IST_W-1:0]  ist;
        logic [CHAN_W-1:0] chan;
    } cmd_word_t;

    typedef enum logic [1:0] {
        QS_IDLE   = 2'd0,
        QS_RUN    = 2'd1,
        QS_HOLD   = 2'd2
    } qstate_e;

    function automatic logic is_end_word(cmd_word_t w);
        return w.chan == END_CHAN;
    endfunction

endpackage

// File: rtl/cmdq_queue_ctl.sv
module cmdq_queue_ctl
    import cmdq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic              trig,
    input  logic              stop,
    input  logic              kill,
    input  logic              end_hit,
    input  logic              conv_fin,
    input  logic              fin_pause,
    output logic              flush,
    output logic              trig_ok,
    output logic              active,
    output logic              paused,
    output logic              done_pls,
    output logic [IDX_W-1:0]  ptr
);

    qstate_e           st_q;
    logic [MODE_W-1:0] mode_q;
    logic [IDX_W-1:0]  ptr_q;
    logic              done_q;

    // A flush comes from stop, the disabled mode or any change of mode.
    assign flush    = stop | (mode == MODE_OFF) | (mode != mode_q);
    assign trig_ok  = trig & ~flush;
    assign active   = (st_q == QS_RUN);
    assign paused   = (st_q == QS_HOLD);
    assign done_pls = done_q;
    assign ptr      = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= QS_IDLE;
            mode_q <= MODE_OFF;
            ptr_q  <= '0;
            done_q <= 1'b0;
        end else begin
            mode_q <= mode;
            done_q <= 1'b0;
            if (flush || kill) begin
                st_q <= QS_IDLE;
            end else if (end_hit) begin
                st_q   <= QS_IDLE;
                done_q <= 1'b1;
            end else if (conv_fin) begin
                ptr_q <= ptr_q + 1'b1;
                st_q  <= fin_pause ? QS_HOLD : QS_RUN;
            end else if (trig) begin
                case (st_q)
                    QS_IDLE: begin
                        ptr_q <= base_idx;
                        st_q  <= QS_RUN;
                    end
                    QS_HOLD: st_q <= QS_RUN;
                    default: ;
                endcase
            end
        end
    end

    // R5
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_fin && fin_pause && !flush && !kill) |=> paused);

    // R4
    end_word_chk: assert property (@(posedge clk) disable iff (rst)
        (end_hit && !flush && !kill) |=> (done_pls && !active && !paused));

    // R9
    flush_idle_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!active && !paused));

    // R6
    retrig_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (active && trig && !flush && !kill && !conv_fin && !end_hit)
        |=> (active && $stable(ptr)));

endmodule

// File: rtl/cmdq_issue.sv
module cmdq_issue
    import cmdq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             free,
    input  logic [1:0]       act_v,
    input  logic [1:0]       flush_v,
    input  logic             q1_trig_ok,
    input  logic [IDX_W-1:0] ptr1,
    input  logic [IDX_W-1:0] ptr2,
    input  logic [WORD_W-1:0] tbl_data,
    output logic [IDX_W-1:0] tbl_addr,
    output logic             go,
    output logic             go_sel,
    output logic             go_end,
    output cmd_word_t        word
);

    logic can1;
    logic can2;
    logic rsvd_unused;

    // Queue 2 also yields in any cycle in which queue 1 is being triggered.
    assign can1     = act_v[0] & ~flush_v[0];
    assign can2     = act_v[1] & ~flush_v[1] & ~q1_trig_ok;
    assign go       = free & (can1 | can2);
    assign go_sel   = ~can1;
    assign tbl_addr = go_sel ? ptr2 : ptr1;
    assign word     = cmd_word_t'(tbl_data);
    assign go_end   = go & is_end_word(word);
    assign rsvd_unused = ^word.rsvd;

endmodule

// File: rtl/cmdq_sequencer.sv
module cmdq_sequencer
    import cmdq_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        q1_mode,
    input  logic [1:0]        q2_mode,
    input  logic [IDX_W-1:0]  q2_base,
    input  logic              q1_trig,
    input  logic              q2_trig,
    input  logic              stop,
    input  logic              frz_en,
    input  logic              frz_in,
    output logic [IDX_W-1:0]  tbl_addr,
    input  logic [15:0]       tbl_data,
    output logic              cnv_start,
    output logic              cnv_abort,
    output logic [5:0]        cnv_chan,
    output logic              cnv_byp,
    output logic [1:0]        cnv_ist,
    input  logic              cnv_done,
    input  logic [DATA_W-1:0] cnv_data,
    output logic              res_valid,
    output logic              res_qsel,
    output logic [IDX_W-1:0]  res_idx,
    output logic [DATA_W-1:0] res_data,
    output logic              q1_done,
    output logic              q2_done,
    output logic              q1_paused,
    output logic              q2_paused,
    output logic              q2_abrt,
    output logic [IDX_W-1:0]  q2_abrt_idx
);

    localparam int NQ = 2;

    logic [NQ-1:0][MODE_W-1:0] mode_v;
    logic [NQ-1:0][IDX_W-1:0]  base_v;
    logic [NQ-1:0][IDX_W-1:0]  ptr_v;
    logic [NQ-1:0] trig_v, kill_v, end_v, fin_v;
    logic [NQ-1:0] flush_v, trig_ok_v, act_v, paused_v, done_v;

    logic             busy_q, own_q, pause_q;
    logic [IDX_W-1:0] idx_q;
    logic             abrt_q;
    logic [IDX_W-1:0] abrt_idx_q;

    logic      fin, preempt, abort, frozen, free;
    logic      go, go_sel, go_end;
    cmd_word_t word;
    logic      trig2_unused;

    assign mode_v = {q2_mode, q1_mode};
    assign base_v = {q2_base, {IDX_W{1'b0}}};
    assign trig_v = {q2_trig, q1_trig};

    // Converter handshake qualifiers.
    assign fin     = busy_q & cnv_done;
    assign preempt = busy_q & ~cnv_done & own_q & trig_ok_v[0];
    assign abort   = busy_q & ~cnv_done & (flush_v[own_q] | preempt);
    assign frozen  = frz_en & frz_in;
    assign free    = ~busy_q & ~stop & ~frozen;

    assign kill_v = {preempt, 1'b0};
    assign fin_v  = {fin & own_q, fin & ~own_q};
    assign end_v  = {go_end & go_sel, go_end & ~go_sel};
    assign trig2_unused = trig_ok_v[1];

    for (genvar gi = 0; gi < NQ; gi++) begin : g_queue
        cmdq_queue_ctl #(.IDX_W(IDX_W)) q_i (
            .clk       (clk),
            .rst       (rst),
            .mode      (mode_v[gi]),
            .base_idx  (base_v[gi]),
            .trig      (trig_v[gi]),
            .stop      (stop),
            .kill      (kill_v[gi]),
            .end_hit   (end_v[gi]),
            .conv_fin  (fin_v[gi]),
            .fin_pause (pause_q),
            .flush     (flush_v[gi]),
            .trig_ok   (trig_ok_v[gi]),
            .active    (act_v[gi]),
            .paused    (paused_v[gi]),
            .done_pls  (done_v[gi]),
            .ptr       (ptr_v[gi])
        );
    end

    cmdq_issue #(.IDX_W(IDX_W)) issue_i (
        .free       (free),
        .act_v      (act_v),
        .flush_v    (flush_v),
        .q1_trig_ok (trig_ok_v[0]),
        .ptr1       (ptr_v[0]),
        .ptr2       (ptr_v[1]),
        .tbl_data   (tbl_data),
        .tbl_addr   (tbl_addr),
        .go         (go),
        .go_sel     (go_sel),
        .go_end     (go_end),
        .word       (word)
    );

    assign cnv_start = go & ~go_end;
    assign cnv_abort = abort;
    assign cnv_chan  = word.chan;
    assign cnv_byp   = word.byp;
    assign cnv_ist   = word.ist;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            own_q      <= 1'b0;
            pause_q    <= 1'b0;
            idx_q      <= '0;
            abrt_q     <= 1'b0;
            abrt_idx_q <= '0;
        end else begin
            abrt_q <= preempt;
            if (preempt) begin
                abrt_idx_q <= idx_q;
            end
            if (cnv_start) begin
                busy_q  <= 1'b1;
                own_q   <= go_sel;
                idx_q   <= tbl_addr;
                pause_q <= word.pause;
            end else if (fin || abort) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign res_valid   = fin;
    assign res_qsel    = own_q;
    assign res_idx     = idx_q;
    assign res_data    = cnv_data;
    assign q1_done     = done_v[0];
    assign q2_done     = done_v[1];
    assign q1_paused   = paused_v[0];
    assign q2_paused   = paused_v[1];
    assign q2_abrt     = abrt_q;
    assign q2_abrt_idx = abrt_idx_q;

    // R8
    preempt_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && own_q && trig_ok_v[0] && !cnv_done)
        |-> cnv_abort ##1 (q2_abrt && q2_abrt_idx == $past(idx_q)));

    // R9
    disable_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !own_q && q1_mode == MODE_OFF && !cnv_done) |-> cnv_abort);

    // R11
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!busy_q && !cnv_start));

    // R12
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frz_en && frz_in) |-> !cnv_start);

    // R2
    single_flight_chk: assert property (@(posedge clk) disable iff (rst)
        cnv_start |=> !cnv_start);

endmodule

// File: tb/cmdq_sequencer_tb.sv
module cmdq_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 6;
    localparam int DATA_W     = 10;
    localparam int LAT        = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] q1_mode = 2'd0, q2_mode = 2'd0;
    logic [IDX_W-1:0] q2_base = '0;
    logic q1_trig = 1'b0, q2_trig = 1'b0, stop = 1'b0, frz_en = 1'b0, frz_in = 1'b0;
    logic [IDX_W-1:0] tbl_addr;
    logic [15:0] tbl_data;
    logic cnv_start, cnv_abort, cnv_byp, cnv_done;
    logic [5:0] cnv_chan;
    logic [1:0] cnv_ist;
    logic [DATA_W-1:0] cnv_data;
    logic res_valid, res_qsel;
    logic [IDX_W-1:0] res_idx, q2_abrt_idx;
    logic [DATA_W-1:0] res_data;
    logic q1_done, q2_done, q1_paused, q2_paused, q2_abrt;

    logic [15:0] tbl [64];
    assign tbl_data = tbl[tbl_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdq_sequencer #(.IDX_W(IDX_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .q1_mode(q1_mode), .q2_mode(q2_mode), .q2_base(q2_base),
        .q1_trig(q1_trig), .q2_trig(q2_trig), .stop(stop), .frz_en(frz_en), .frz_in(frz_in),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data), .cnv_start(cnv_start), .cnv_abort(cnv_abort),
        .cnv_chan(cnv_chan), .cnv_byp(cnv_byp), .cnv_ist(cnv_ist), .cnv_done(cnv_done),
        .cnv_data(cnv_data), .res_valid(res_valid), .res_qsel(res_qsel), .res_idx(res_idx),
        .res_data(res_data), .q1_done(q1_done), .q2_done(q2_done), .q1_paused(q1_paused),
        .q2_paused(q2_paused), .q2_abrt(q2_abrt), .q2_abrt_idx(q2_abrt_idx)
    );

    // Fixed-latency converter model.
    int cnt;
    logic [5:0] cur_ch;
    always @(posedge clk) begin
        if (rst) begin
            cnt <= 0; cur_ch <= '0;
        end else if (cnv_start) begin
            cnt <= LAT; cur_ch <= cnv_chan;
        end else if (cnv_abort) begin
            cnt <= 0;
        end else if (cnt > 0) begin
            cnt <= cnt - 1;
        end
    end
    assign cnv_done = (cnt == 1);
    assign cnv_data = {4'b1010, cur_ch};

    // Output monitor, sampled on the falling edge.
    int n_res, n_st, n_d1, n_d2, n_abrt, n_cab;
    logic [IDX_W-1:0] log_idx [256];
    logic [DATA_W-1:0] log_dat [256];
    logic log_q [256];
    logic [8:0] log_st [256];
    logic [IDX_W-1:0] last_abrt;
    always @(negedge clk) begin
        if (!rst) begin
            if (res_valid) begin
                log_idx[n_res[7:0]] = res_idx;
                log_dat[n_res[7:0]] = res_data;
                log_q[n_res[7:0]]   = res_qsel;
                n_res++;
            end
            if (cnv_start) begin
                log_st[n_st[7:0]] = {cnv_byp, cnv_ist, cnv_chan};
                n_st++;
            end
            if (q1_done) n_d1++;
            if (q2_done) n_d2++;
            if (cnv_abort) n_cab++;
            if (q2_abrt) begin n_abrt++; last_abrt = q2_abrt_idx; end
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic run(input int c);
        repeat (c) tick();
    endtask

    task automatic clr_log();
        n_res = 0; n_st = 0; n_d1 = 0; n_d2 = 0; n_abrt = 0; n_cab = 0;
    endtask

    task automatic pulse(input bit q1, input bit q2);
        q1_trig = q1; q2_trig = q2;
        tick();
        q1_trig = 1'b0; q2_trig = 1'b0;
    endtask

    task automatic wait_st(input int n);
        for (int g = 0; g < 300 && n_st < n; g++) tick();
    endtask

    function automatic logic [15:0] mk(input bit p, input bit b, input logic [1:0] t, input logic [5:0] c);
        return {6'b0, p, b, t, c};
    endfunction

    function automatic logic [DATA_W-1:0] exp_dat(input int i);
        return {4'b1010, tbl[i][5:0]};
    endfunction

    task automatic fill(input int base, input int n);
        for (int i = 0; i < n; i++)
            tbl[base+i] = mk(1'b0, i[0], i[2:1], 6'(5 + 3*i + base));
        tbl[base+n] = mk(1'b0, 1'b0, 2'd0, 6'd63);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) tbl[i] = mk(1'b0, 1'b0, 2'd0, 6'd63);
        clr_log();
        run(3);
        // R2: reset state
        chk(cnv_start == 1'b0 && res_valid == 1'b0, "R2 reset outputs", int'(cnv_start), 0);
        chk(q1_paused == 1'b0 && q2_abrt == 1'b0, "R5 reset pause", int'(q1_paused), 0);
        rst = 1'b0;
        q1_mode = 2'd1; q2_mode = 2'd1; q2_base = 6'd32;
        run(2);

        // R1 R2 R3 R4: sweep queue 1 lengths 0..8
        for (int n = 0; n <= 8; n++) begin
            fill(0, n);
            clr_log();
            pulse(1'b1, 1'b0);
            run(n * 6 + 10);
            chk(n_res == n, "R2 result count", n_res, n);
            chk(n_d1 == 1, "R4 queue1 done pulse", n_d1, 1);
            for (int i = 0; i < n; i++) begin
                chk(log_idx[i] == IDX_W'(i), "R2 index order", int'(log_idx[i]), i);
                chk(log_dat[i] == exp_dat(i) && log_q[i] == 1'b0, "R3 result tag", int'(log_dat[i]), int'(exp_dat(i)));
                chk(log_st[i] == tbl[i][8:0], "R1 field forward", int'(log_st[i]), int'(tbl[i][8:0]));
            end
        end

        // R2 R3 R4: queue 2 from its base index
        fill(32, 3);
        clr_log();
        pulse(1'b0, 1'b1);
        run(30);
        chk(n_res == 3 && n_d2 == 1, "R4 queue2 end", n_res, 3);
        for (int i = 0; i < 3; i++)
            chk(log_idx[i] == IDX_W'(32 + i) && log_q[i] == 1'b1, "R3 queue2 tag", int'(log_idx[i]), 32 + i);

        // R7: both queues triggered together, queue 1 first
        fill(0, 3);
        clr_log();
        pulse(1'b1, 1'b1);
        run(50);
        chk(n_res == 6, "R7 total results", n_res, 6);
        for (int i = 0; i < 6; i++)
            chk(log_idx[i] == IDX_W'(i < 3 ? i : 29 + i), "R7 priority order", int'(log_idx[i]), i < 3 ? i : 29 + i);

        // R6: re-trigger while running is ignored
        clr_log();
        pulse(1'b1, 1'b0);
        run(6);
        pulse(1'b1, 1'b0);
        run(30);
        chk(n_res == 3 && n_d1 == 1, "R6 retrigger ignored", n_res, 3);

        // R5: pause points
        fill(0, 4);
        tbl[1][9] = 1'b1;
        clr_log();
        pulse(1'b1, 1'b0);
        run(30);
        chk(n_res == 2 && n_st == 2, "R5 held at pause", n_res, 2);
        chk(q1_paused == 1'b1, "R5 paused flag", int'(q1_paused), 1);
        pulse(1'b1, 1'b0);
        run(30);
        chk(n_res == 4 && log_idx[2] == 6'd2 && log_idx[3] == 6'd3, "R5 resume next index", int'(log_idx[2]), 2);
        chk(n_d1 == 1 && q1_paused == 1'b0, "R5 run to end", n_d1, 1);

        // R8: queue 1 pre-empts queue 2
        fill(0, 2);
        fill(32, 8);
        clr_log();
        pulse(1'b0, 1'b1);
        wait_st(3);
        pulse(1'b1, 1'b0);
        run(40);
        chk(n_abrt == 1 && last_abrt == 6'd34, "R8 abort index", int'(last_abrt), 34);
        chk(n_cab == 1, "R8 converter abort", n_cab, 1);
        chk(n_res == 4 && log_idx[2] == 6'd0 && log_idx[3] == 6'd1, "R8 queue1 runs, queue2 idle", n_res, 4);
        pulse(1'b0, 1'b1);
        run(60);
        chk(n_res == 12 && log_idx[4] == 6'd32, "R8 queue2 restarts at base", int'(log_idx[4]), 32);

        // R9: disable mode
        fill(0, 6);
        clr_log();
        pulse(1'b1, 1'b0);
        wait_st(2);
        q1_mode = 2'd0;
        run(30);
        chk(n_res == 1 && n_cab == 1, "R9 disable aborts", n_res, 1);
        pulse(1'b1, 1'b0);
        run(30);
        chk(n_st == 2, "R9 trigger ignored while disabled", n_st, 2);
        q1_mode = 2'd1;
        run(2);
        pulse(1'b1, 1'b0);
        run(50);
        chk(n_res == 7 && log_idx[1] == 6'd0, "R9 restart after enable", int'(log_idx[1]), 0);

        // R10: mode change
        clr_log();
        pulse(1'b1, 1'b0);
        wait_st(3);
        q1_mode = 2'd2;
        run(20);
        chk(n_res == 2 && n_cab == 1, "R10 mode change aborts", n_res, 2);
        pulse(1'b1, 1'b0);
        run(50);
        chk(n_res == 8 && log_idx[2] == 6'd0, "R10 restart from base", int'(log_idx[2]), 0);
        q1_mode = 2'd1;
        run(2);

        // R11: stop
        clr_log();
        pulse(1'b0, 1'b1);
        wait_st(2);
        stop = 1'b1;
        tick();
        pulse(1'b1, 1'b1);
        run(20);
        chk(n_st == 2 && n_res == 1 && n_cab == 1, "R11 stop aborts and blocks", n_st, 2);
        stop = 1'b0;
        tick();
        pulse(1'b0, 1'b1);
        run(60);
        chk(n_res == 9 && log_idx[1] == 6'd32, "R11 restart after stop", int'(log_idx[1]), 32);

        // R12: freeze
        frz_en = 1'b1;
        clr_log();
        pulse(1'b1, 1'b0);
        wait_st(2);
        frz_in = 1'b1;
        run(30);
        chk(n_res == 2 && n_st == 2, "R12 in-flight completes, none issued", n_st, 2);
        frz_in = 1'b0;
        run(50);
        chk(n_res == 6 && log_idx[2] == 6'd2, "R12 resume next index", int'(log_idx[2]), 2);
        frz_en = 1'b0;
        frz_in = 1'b1;
        clr_log();
        pulse(1'b1, 1'b0);
        run(50);
        chk(n_res == 6 && n_d1 == 1, "R12 freeze ignored when not enabled", n_res, 6);
        frz_in = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule